// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands held in sign-magnitude form. Each operand has a sign bit, an unsigned exponent and a fractional mantissa whose value is `mant / 2^MW`. A normalized operand has the mantissa MSB set. An all-zero mantissa with exponent zero stands for the value zero. The result is returned in the same fractional form.

The work is split into four register-bounded segments. The first segment compares the exponents by subtraction. The second picks the larger exponent and right-shifts the smaller operand's mantissa into line with it. The third adds or subtracts the magnitudes. The fourth renormalizes the result, adjusts the exponent and flags any exponent wrap. One operand pair may enter on every clock. A valid bit travels alongside the data, and there is no stall, so a burst of n operations drains in n+3 cycles.

Bits shifted out during alignment are discarded, which is plain truncation. There is no rounding.

Top module: `fp_add_pipe`

## Requirements
- R1: A result appears on the outputs exactly 4 clock edges after its operands are sampled with `in_valid` high. Back-to-back inputs on consecutive cycles produce results on consecutive cycles.
- R2: The result exponent is taken from the operand with the larger exponent. The other operand's mantissa is shifted right by the exponent difference before the add, whichever operand that is.
- R3: When the exponent difference is at least MW, the aligned mantissa of the smaller operand is zero. The result is then the larger operand's mantissa, exponent and sign.
- R4: With `in_sub` = 0 the operation is a + b. With `in_sub` = 1 it is a - b, performed by inverting b's sign. Operands of equal effective sign have their magnitudes added, and the result keeps that sign.
- R5: Operands of opposite effective sign have the smaller magnitude subtracted from the larger. The result takes the sign of the larger-magnitude operand.
- R6: A magnitude sum that carries out of the MW-bit mantissa is shifted right by one place, and the exponent is incremented.
- R7: A nonzero magnitude with k leading zeros is shifted left by k places so its MSB is 1, and the exponent is decremented by k.
- R8: A zero magnitude result gives mantissa 0, exponent 0 and sign 0.
- R9: If the exponent increment of R6 passes 2^EW-1, `out_ovf` is 1 and `out_exp` holds the low EW bits of the increment (that is, 0).
- R10: If k in R7 exceeds the exponent, `out_unf` is 1 and `out_exp` holds the low EW bits of exponent minus k.
- R11: While `rst` is high, and after it falls until the first result arrives, `out_valid`, `out_ovf` and `out_unf` are 0.
- R12: A cycle with `in_valid` low yields `out_valid` low 4 edges later. The flags are only ever 1 alongside `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_sub | input | 1 | 0 = add, 1 = subtract b from a |
| a_sign | input | 1 | Sign of operand a (1 = negative) |
| a_exp | input | EW | Exponent of operand a |
| a_mant | input | MW | Fractional mantissa of operand a |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | EW | Exponent of operand b |
| b_mant | input | MW | Fractional mantissa of operand b |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | EW | Result exponent |
| out_mant | output | MW | Normalized result mantissa |
| out_ovf | output | 1 | Exponent overflow on this result |
| out_unf | output | 1 | Exponent underflow on this result |

## Verification
Every result is due 4 rising edges after its operands are driven. The bench drives inputs on the falling edge. On the falling edge four iterations later, it compares the output fields with the expected values stored for that vector. Because the table is streamed with one vector per cycle, the same walk also shows that results come out back to back. The directed tests for bubbles and for reset sample at the same four-edge offset.

// File: rtl/fp_add_pipe.sv
module fp_add_pipe #(
  parameter int MW = 16,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sub,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [MW-1:0] a_mant,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [MW-1:0] b_mant,
  output logic          out_valid,
  output logic          out_sign,
  output logic [EW-1:0] out_exp,
  output logic [MW-1:0] out_mant,
  output logic          out_ovf,
  output logic          out_unf
);
  localparam int SW = $clog2(MW + 1);

  // segment 1: exponent compare
  logic [EW:0]   ediff;
  logic          a_small;
  logic [EW-1:0] dmag;
  assign ediff   = {1'b0, a_exp} - {1'b0, b_exp};
  assign a_small = ediff[EW];
  assign dmag    = a_small ? (b_exp - a_exp) : ediff[EW-1:0];

  logic          s1_v, s1_swap, s1_sa, s1_sb;
  logic [EW-1:0] s1_sh, s1_ea, s1_eb;
  logic [MW-1:0] s1_ma, s1_mb;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_swap <= 1'b0; s1_sa <= 1'b0; s1_sb <= 1'b0;
      s1_sh <= '0; s1_ea <= '0; s1_eb <= '0; s1_ma <= '0; s1_mb <= '0;
    end else begin
      s1_v    <= in_valid;
      s1_swap <= a_small;
      s1_sh   <= dmag;
      s1_sa   <= a_sign;
      s1_sb   <= b_sign ^ in_sub;
      s1_ea   <= a_exp;
      s1_eb   <= b_exp;
      s1_ma   <= a_mant;
      s1_mb   <= b_mant;
    end
  end

  // segment 2: choose exponent, align
  logic [MW-1:0] big_m, sml_m, sml_al;
  logic          big_s, sml_s, sat;
  assign big_m  = s1_swap ? s1_mb : s1_ma;
  assign sml_m  = s1_swap ? s1_ma : s1_mb;
  assign big_s  = s1_swap ? s1_sb : s1_sa;
  assign sml_s  = s1_swap ? s1_sa : s1_sb;
  assign sat    = {{(32-EW){1'b0}}, s1_sh} >= 32'(MW);
  assign sml_al = sat ? '0 : (sml_m >> s1_sh);

  logic          s2_v, s2_sx, s2_sy;
  logic [EW-1:0] s2_e;
  logic [MW-1:0] s2_mx, s2_my;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0; s2_sx <= 1'b0; s2_sy <= 1'b0;
      s2_e <= '0; s2_mx <= '0; s2_my <= '0;
    end else begin
      s2_v  <= s1_v;
      s2_e  <= s1_swap ? s1_eb : s1_ea;
      s2_mx <= big_m;
      s2_my <= sml_al;
      s2_sx <= big_s;
      s2_sy <= sml_s;
    end
  end

  // segment 3: magnitude add/subtract
  logic [MW:0] mag;
  logic        mag_s;
  always_comb begin
    if (s2_sx == s2_sy) begin
      mag   = {1'b0, s2_mx} + {1'b0, s2_my};
      mag_s = s2_sx;
    end else if (s2_mx >= s2_my) begin
      mag   = {1'b0, s2_mx} - {1'b0, s2_my};
      mag_s = s2_sx;
    end else begin
      mag   = {1'b0, s2_my} - {1'b0, s2_mx};
      mag_s = s2_sy;
    end
  end

  logic          s3_v, s3_s;
  logic [EW-1:0] s3_e;
  logic [MW:0]   s3_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_v <= 1'b0; s3_s <= 1'b0; s3_e <= '0; s3_m <= '0;
    end else begin
      s3_v <= s2_v;
      s3_s <= mag_s;
      s3_e <= s2_e;
      s3_m <= mag;
    end
  end

  // segment 4: normalize, adjust exponent
  function automatic logic [SW-1:0] lead_zeros(input logic [MW-1:0] v);
    logic [SW-1:0] n;
    logic          hit;
    n   = '0;
    hit = 1'b0;
    for (int i = MW - 1; i >= 0; i--) begin
      if (v[i]) hit = 1'b1;
      else if (!hit) n = n + 1'b1;
    end
    return n;
  endfunction

  logic [SW-1:0] lz;
  logic [EW:0]   e_inc, e_dec;
  logic          n_s, n_ovf, n_unf;
  logic [EW-1:0] n_e;
  logic [MW-1:0] n_m;

  assign lz    = lead_zeros(s3_m[MW-1:0]);
  assign e_inc = {1'b0, s3_e} + 1'b1;
  assign e_dec = {1'b0, s3_e} - (EW+1)'(lz);

  always_comb begin
    n_s = s3_s; n_ovf = 1'b0; n_unf = 1'b0;
    if (s3_m[MW]) begin
      n_m   = s3_m[MW:1];
      n_e   = e_inc[EW-1:0];
      n_ovf = e_inc[EW];
    end else if (s3_m == '0) begin
      n_m = '0;
      n_e = '0;
      n_s = 1'b0;
    end else begin
      n_m   = s3_m[MW-1:0] << lz;
      n_e   = e_dec[EW-1:0];
      n_unf = e_dec[EW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; out_sign <= 1'b0; out_exp <= '0; out_mant <= '0;
      out_ovf <= 1'b0; out_unf <= 1'b0;
    end else begin
      out_valid <= s3_v;
      out_sign  <= n_s;
      out_exp   <= n_e;
      out_mant  <= n_m;
      out_ovf   <= s3_v & n_ovf;
      out_unf   <= s3_v & n_unf;
    end
  end
endmodule

// File: rtl/fp_add_pipe_chk.sv
module fp_add_pipe_chk #(
  parameter int MW = 16,
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic          out_sign,
  input logic [EW-1:0] out_exp,
  input logic [MW-1:0] out_mant,
  input logic          out_ovf,
  input logic          out_unf
);
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  assert_normalized_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mant != '0) |-> out_mant[MW-1]);

  assert_zero_form_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mant == '0) |-> (out_exp == '0 && !out_sign && !out_ovf && !out_unf));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(out_ovf && out_unf));

  assert_flags_need_valid_R12: assert property (@(posedge clk) disable iff (rst)
    (out_ovf || out_unf) |-> out_valid);

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_ovf && !out_unf));
endmodule

bind fp_add_pipe fp_add_pipe_chk #(.MW(MW), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant),
  .out_ovf(out_ovf), .out_unf(out_unf)
);

// File: tb/tb_fp_add_pipe.sv
module tb_fp_add_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 8;
  localparam int EW = 6;

  typedef struct packed {
    logic          sub;
    logic          sa;
    logic [EW-1:0] ea;
    logic [MW-1:0] ma;
    logic          sb;
    logic [EW-1:0] eb;
    logic [MW-1:0] mb;
    logic          rs;
    logic [EW-1:0] re;
    logic [MW-1:0] rm;
    logic          ov;
    logic          un;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 6'd3,  8'hC0, 1'b0, 6'd2,  8'h80, 1'b0, 6'd4,  8'h80, 1'b0, 1'b0}, // R6 carry
    '{1'b0, 1'b0, 6'd5,  8'h80, 1'b0, 6'd5,  8'h80, 1'b0, 6'd6,  8'h80, 1'b0, 1'b0}, // R6 equal exps
    '{1'b0, 1'b0, 6'd10, 8'hA0, 1'b0, 6'd7,  8'h90, 1'b0, 6'd10, 8'hB2, 1'b0, 1'b0}, // R2 a larger
    '{1'b0, 1'b0, 6'd4,  8'h88, 1'b0, 6'd6,  8'hF0, 1'b0, 6'd7,  8'h89, 1'b0, 1'b0}, // R2 b larger
    '{1'b0, 1'b0, 6'd20, 8'h90, 1'b0, 6'd12, 8'hFF, 1'b0, 6'd20, 8'h90, 1'b0, 1'b0}, // R3 diff=MW
    '{1'b0, 1'b0, 6'd20, 8'h90, 1'b0, 6'd13, 8'hFF, 1'b0, 6'd20, 8'h91, 1'b0, 1'b0}, // R3 diff=MW-1
    '{1'b1, 1'b0, 6'd5,  8'hC0, 1'b0, 6'd5,  8'h80, 1'b0, 6'd4,  8'h80, 1'b0, 1'b0}, // R7 one zero
    '{1'b0, 1'b0, 6'd5,  8'h80, 1'b1, 6'd5,  8'hC0, 1'b1, 6'd4,  8'h80, 1'b0, 1'b0}, // R5 neg result
    '{1'b1, 1'b0, 6'd9,  8'hA5, 1'b0, 6'd9,  8'hA5, 1'b0, 6'd0,  8'h00, 1'b0, 1'b0}, // R8 zero
    '{1'b1, 1'b0, 6'd6,  8'h81, 1'b0, 6'd6,  8'h80, 1'b0, 6'd63, 8'h80, 1'b0, 1'b1}, // R10 underflow
    '{1'b1, 1'b0, 6'd7,  8'h81, 1'b0, 6'd7,  8'h80, 1'b0, 6'd0,  8'h80, 1'b0, 1'b0}, // R7 lz=exp
    '{1'b0, 1'b0, 6'd63, 8'h80, 1'b0, 6'd63, 8'h80, 1'b0, 6'd0,  8'h80, 1'b1, 1'b0}, // R9 overflow
    '{1'b0, 1'b1, 6'd3,  8'hC0, 1'b1, 6'd2,  8'h80, 1'b1, 6'd4,  8'h80, 1'b0, 1'b0}, // R4 both neg
    '{1'b1, 1'b0, 6'd3,  8'hC0, 1'b1, 6'd2,  8'h80, 1'b0, 6'd4,  8'h80, 1'b0, 1'b0}, // R4 sub negative
    '{1'b1, 1'b0, 6'd4,  8'h80, 1'b0, 6'd3,  8'hFF, 1'b0, 6'd61, 8'h80, 1'b0, 1'b1}, // R10 aligned sub
    '{1'b0, 1'b0, 6'd0,  8'h00, 1'b0, 6'd5,  8'hA0, 1'b0, 6'd5,  8'hA0, 1'b0, 1'b0}  // R2 zero operand
  };

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_sub, a_sign, b_sign;
  logic [EW-1:0] a_exp, b_exp;
  logic [MW-1:0] a_mant, b_mant;
  logic out_valid, out_sign, out_ovf, out_unf;
  logic [EW-1:0] out_exp;
  logic [MW-1:0] out_mant;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_add_pipe #(.MW(MW), .EW(EW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sub(in_sub),
    .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_mant(out_mant), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    in_valid = vld; in_sub = v.sub;
    a_sign = v.sa; a_exp = v.ea; a_mant = v.ma;
    b_sign = v.sb; b_exp = v.eb; b_mant = v.mb;
  endtask

  function automatic logic [31:0] pack_out();
    return {8'h0, out_valid, out_sign, out_exp, out_mant, out_ovf, out_unf, 8'h0};
  endfunction

  function automatic logic [31:0] pack_exp(input vec_t v);
    return {8'h0, 1'b1, v.rs, v.re, v.rm, v.ov, v.un, 8'h0};
  endfunction

  initial begin
    rst = 1'b1;
    drive('0, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 reset valid/flags", {29'd0, out_valid, out_ovf, out_unf}, 32'd0);
    rst = 1'b0;

    // stream the whole table back to back; each result due 4 edges later (R1)
    for (int j = 0; j < NV + 4; j++) begin
      if (j >= 4) check($sformatf("R1 vector %0d result", j - 4), pack_out(), pack_exp(VEC[j-4]));
      else check("R11 no result before fill", {31'd0, out_valid}, 32'd0);
      if (j < NV) drive(VEC[j], 1'b1);
      else drive('0, 1'b0);
      @(negedge clk);
    end
    check("R12 drained pipe", {31'd0, out_valid}, 32'd0);

    // bubble between two valid pairs: valid data on invalid cycle must not emerge
    drive(VEC[0], 1'b1); @(negedge clk);
    drive(VEC[11], 1'b0); @(negedge clk);
    drive(VEC[2], 1'b1); @(negedge clk);
    drive('0, 1'b0); @(negedge clk);
    check("R1 bubble first", pack_out(), pack_exp(VEC[0]));
    @(negedge clk);
    check("R12 bubble slot", {29'd0, out_valid, out_ovf, out_unf}, 32'd0);
    @(negedge clk);
    check("R1 bubble third", pack_out(), pack_exp(VEC[2]));

    // reset mid-flight discards in-flight work
    drive(VEC[11], 1'b1); @(negedge clk);
    drive('0, 1'b0); @(negedge clk);
    rst = 1'b1; @(negedge clk);
    rst = 1'b0;
    check("R11 reset in flight", {29'd0, out_valid, out_ovf, out_unf}, 32'd0);
    @(negedge clk);
    check("R11 after reset", {29'd0, out_valid, out_ovf, out_unf}, 32'd0);
    @(negedge clk);
    check("R11 after reset 2", {29'd0, out_valid, out_ovf, out_unf}, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule